// File: doc/BRIEF.md
# SDRAM Command and Address Sequencer

This block sits between a simple host request port and a 32-bit, four-bank synchronous DRAM. Each request names a 23-bit word address, a direction, an auto-precharge choice and a four-bit byte mask. The sequencer splits the address into column, bank and row fields. It keeps a record of which row is open in each bank, and from that record it emits the shortest command sequence that reaches the target word. A request to an open row gets only the read or write. A request to a closed bank gets an activate first. A request to a different row in an open bank gets a single-bank precharge, then an activate. Fixed gaps of deselect cycles separate the commands.

A refresh request closes every open bank with one all-bank precharge and then issues an auto-refresh. A power-down request taken while no access is running drops the clock-enable line and keeps it low for as long as the request is held. The byte mask follows the device's two latencies: a write mask goes out on the write command cycle itself, and a read mask goes out `CAS_LAT-2` cycles after the read command, so that it takes effect on the returning data.

The controller has eight states. `ST_IDLE` waits for work. From there it goes to `ST_PREALL` when a refresh is requested and a bank is open, to `ST_REF` when a refresh is requested and no bank is open, to `ST_PDOWN` on a power-down request, and for an access to `ST_ACT`, `ST_PRE` or `ST_RW` (closed bank, row miss, row hit). The one-cycle command states lead into `ST_WAIT`, which counts down a gap and then moves on. The transitions out of `ST_WAIT` are: after `ST_PRE` to `ST_ACT`, after `ST_ACT` to `ST_RW`, after `ST_RW` to `ST_IDLE`, after `ST_PREALL` to `ST_REF`, and after `ST_REF` to `ST_IDLE`. `ST_PDOWN` returns to `ST_IDLE` when the power-down request drops.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, clock-enable is high, the command lines {cs_n,ras_n,cas_n,we_n} are 1111, bank and address are zero, all four mask lines are high, and req_ready is high when no refresh or power-down is requested.
- R2: The host address is split with the column in bits 8:0, the bank in bits 10:9 and the row in bits 22:11. An activate (command 0011) carries the row on A11..A0 and the bank on the bank lines, with the masks high.
- R3: A read (command 0101) or write (command 0100) carries the column on A8..A0 and the target bank on the bank lines, with A9 and A11 low and A10 equal to the request's auto-precharge flag.
- R4: A request whose bank is open on the same row gets its read or write on the cycle after acceptance, with no precharge or activate.
- R5: A request whose bank is open on a different row gets a precharge (command 0010, A10 low, bank lines set to that bank), then T_RP deselect cycles, then the activate.
- R6: A request to a closed bank starts with the activate, followed by T_RCD deselect cycles before the read or write. After a read or write with auto-precharge, that bank counts as closed.
- R7: On a write command cycle the mask lines equal the host mask (bit 0 for data bits 7:0 up to bit 3 for bits 31:24, high meaning the byte is not written). On every cycle that carries no pending mask, all four lines are high.
- R8: For a read, the host mask appears on the mask lines exactly CAS_LAT-2 cycles after the read command, for one cycle.
- R9: A refresh request with any bank open gives a precharge with A10 high, then T_RP deselect cycles, then an auto-refresh (command 0001), then T_RFC deselect cycles. With no bank open, the auto-refresh comes first. Afterwards every bank counts as closed.
- R10: A power-down request seen in the idle state drives clock-enable low from the next cycle. Clock-enable stays low while the request is held and returns high on the cycle after it drops. A request made during an access takes effect only once the access has finished.
- R11: Every cycle without a command has the command lines at 1111. A read or write is followed by CAS_LAT+T_RP such cycles before the next request can be taken.
- R12: req_ready is high only in the idle state with neither refresh nor power-down requested. In the idle state, refresh has priority over power-down, and power-down has priority over an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all lines change after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle's clock edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| req_addr | input | 23 | Word address {row, bank, column} |
| req_mask | input | 4 | Byte-lane mask, high blocks the lane |
| ref_req | input | 1 | Refresh request |
| pd_req | input | 1 | Power-down request, held for the whole period |
| sd_cke | output | 1 | Clock-enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 4 | Byte-lane masks |

## Verification
The bench builds the block with CAS_LAT=3, T_RP=2, T_RCD=2 and T_RFC=4. With CAS_LAT=3 the read mask goes through a one-stage delay, so a mask that lands on the wrong cycle shows up as a miscompare on a deselect cycle. The short gaps keep every precharge, activate, refresh and power-down sequence to a handful of cycles, so each sequence can be run from every starting bank state. These include a row miss, a bank closed by auto-precharge, a refresh with and without open banks, and a power-down requested during an access or together with a refresh, all within a short run.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_RW,
        ST_WAIT,
        ST_PREALL,
        ST_REF,
        ST_PDOWN
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sd_cmd_t;

    localparam sd_cmd_t CMD_DESEL = 4'b1111;
    localparam sd_cmd_t CMD_ACT   = 4'b0011;
    localparam sd_cmd_t CMD_READ  = 4'b0101;
    localparam sd_cmd_t CMD_WRITE = 4'b0100;
    localparam sd_cmd_t CMD_PRE   = 4'b0010;
    localparam sd_cmd_t CMD_REF   = 4'b0001;

endpackage

// File: rtl/sdseq_bank_table.sv
module sdseq_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_open,
    output logic              look_hit,
    output logic              any_open,
    input  logic              act_en,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              close_en,
    input  logic [BANK_W-1:0] close_bank,
    input  logic              close_all
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[i] <= 1'b0;
                row_q[i]  <= '0;
            end else if (close_all || (close_en && close_bank == BANK_W'(i))) begin
                open_q[i] <= 1'b0;
            end else if (act_en && act_bank == BANK_W'(i)) begin
                open_q[i] <= 1'b1;
                row_q[i]  <= act_row;
            end
        end
    end

    assign look_open = open_q[look_bank];
    assign look_hit  = open_q[look_bank] && (row_q[look_bank] == look_row);
    assign any_open  = |open_q;

    // An activate may only target a bank that is currently closed.
    assert_act_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !open_q[act_bank]);

    // After an all-bank close, no bank is left open.
    assert_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        close_all |=> !any_open);

endmodule

// File: rtl/sdseq_rdmask.sv
module sdseq_rdmask #(
    parameter int LANES = 4,
    parameter int DELAY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LANES-1:0] mask_in,
    output logic             vld,
    output logic [LANES-1:0] mask_out
);
    if (DELAY == 0) begin : g_direct
        assign vld      = push;
        assign mask_out = mask_in;
    end else begin : g_pipe
        logic [DELAY-1:0] v_sr;
        logic [LANES-1:0] m_sr [DELAY];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DELAY; k++) begin
                    v_sr[k] <= 1'b0;
                    m_sr[k] <= '1;
                end
            end else begin
                v_sr[0] <= push;
                m_sr[0] <= mask_in;
                for (int k = 1; k < DELAY; k++) begin
                    v_sr[k] <= v_sr[k-1];
                    m_sr[k] <= m_sr[k-1];
                end
            end
        end

        assign vld      = v_sr[DELAY-1];
        assign mask_out = m_sr[DELAY-1];
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdseq_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int LANES   = 4,
    parameter int CAS_LAT = 3,
    parameter int T_RP    = 2,
    parameter int T_RCD   = 2,
    parameter int T_RFC   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic                            req_autopre,
    input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
    input  logic [LANES-1:0]                req_mask,
    input  logic                            ref_req,
    input  logic                            pd_req,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_a,
    output logic [LANES-1:0]                sd_dqm
);
    localparam int RW_GAP = CAS_LAT + T_RP;
    localparam int RD_DLY = CAS_LAT - 2;
    localparam int MAX_A  = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int MAX_B  = (RW_GAP > T_RFC) ? RW_GAP : T_RFC;
    localparam int MAX_G  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_G + 1);
    localparam int AP_BIT = 10;

    seq_state_e state_q, state_d, ret_q, ret_d;
    logic [CNT_W-1:0] cnt_q, cnt_load;
    logic             cnt_en;

    logic [BANK_W-1:0] in_bank, q_bank;
    logic [ROW_W-1:0]  in_row, q_row;
    logic [COL_W-1:0]  in_col, q_col;
    logic              q_write, q_ap;
    logic [LANES-1:0]  q_mask;

    logic look_open, look_hit, any_open;
    logic accept, rd_vld;
    logic [LANES-1:0] rd_mask;
    sd_cmd_t cmd;

    assign in_col  = req_addr[COL_W-1:0];
    assign in_bank = req_addr[COL_W +: BANK_W];
    assign in_row  = req_addr[COL_W+BANK_W +: ROW_W];

    assign req_ready = (state_q == ST_IDLE) && !ref_req && !pd_req;
    assign accept    = req_ready && req_valid;

    sdseq_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_bank (in_bank),
        .look_row  (in_row),
        .look_open (look_open),
        .look_hit  (look_hit),
        .any_open  (any_open),
        .act_en    (state_q == ST_ACT),
        .act_bank  (q_bank),
        .act_row   (q_row),
        .close_en  ((state_q == ST_PRE) || (state_q == ST_RW && q_ap)),
        .close_bank(q_bank),
        .close_all (state_q == ST_PREALL)
    );

    sdseq_rdmask #(.LANES(LANES), .DELAY(RD_DLY)) u_rdmask (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    ((state_q == ST_RW) && !q_write),
        .mask_in (q_mask),
        .vld     (rd_vld),
        .mask_out(rd_mask)
    );

    // State register, gap counter and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            cnt_q   <= '0;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_write <= 1'b0;
            q_ap    <= 1'b0;
            q_mask  <= '1;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            if (cnt_en) begin
                cnt_q <= cnt_load;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (accept) begin
                q_bank  <= in_bank;
                q_row   <= in_row;
                q_col   <= in_col;
                q_write <= req_write;
                q_ap    <= req_autopre;
                q_mask  <= req_mask;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        cnt_en   = 1'b0;
        cnt_load = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req) begin
                    state_d = any_open ? ST_PREALL : ST_REF;
                end else if (pd_req) begin
                    state_d = ST_PDOWN;
                end else if (req_valid) begin
                    if (!look_open)     state_d = ST_ACT;
                    else if (look_hit)  state_d = ST_RW;
                    else                state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                state_d = ST_WAIT; ret_d = ST_ACT;
                cnt_en = 1'b1; cnt_load = CNT_W'(T_RP - 1);
            end
            ST_ACT: begin
                state_d = ST_WAIT; ret_d = ST_RW;
                cnt_en = 1'b1; cnt_load = CNT_W'(T_RCD - 1);
            end
            ST_RW: begin
                state_d = ST_WAIT; ret_d = ST_IDLE;
                cnt_en = 1'b1; cnt_load = CNT_W'(RW_GAP - 1);
            end
            ST_PREALL: begin
                state_d = ST_WAIT; ret_d = ST_REF;
                cnt_en = 1'b1; cnt_load = CNT_W'(T_RP - 1);
            end
            ST_REF: begin
                state_d = ST_WAIT; ret_d = ST_IDLE;
                cnt_en = 1'b1; cnt_load = CNT_W'(T_RFC - 1);
            end
            ST_WAIT: begin
                if (cnt_q == '0) state_d = ret_q;
            end
            ST_PDOWN: begin
                if (!pd_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        sd_cke = 1'b1;
        cmd    = CMD_DESEL;
        sd_ba  = '0;
        sd_a   = '0;
        unique case (state_q)
            ST_PRE: begin
                cmd   = CMD_PRE;
                sd_ba = q_bank;
            end
            ST_ACT: begin
                cmd   = CMD_ACT;
                sd_ba = q_bank;
                sd_a  = q_row;
            end
            ST_RW: begin
                cmd   = q_write ? CMD_WRITE : CMD_READ;
                sd_ba = q_bank;
                sd_a[COL_W-1:0] = q_col;
                sd_a[AP_BIT]    = q_ap;
            end
            ST_PREALL: begin
                cmd          = CMD_PRE;
                sd_a[AP_BIT] = 1'b1;
            end
            ST_REF:   cmd    = CMD_REF;
            ST_PDOWN: sd_cke = 1'b0;
            default: ;
        endcase
        if (rd_vld)                          sd_dqm = rd_mask;
        else if (state_q == ST_RW && q_write) sd_dqm = q_mask;
        else                                  sd_dqm = '1;
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // Power-down: clock-enable may not rise while the request is still held.
    assert_pd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && pd_req) |=> !sd_cke);

    // Column commands keep the unused upper address bits low.
    assert_col_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> (sd_a[9] == 1'b0 && sd_a[ROW_W-1:11] == '0));

    // A delayed read mask never lands on a write command cycle.
    assert_mask_noclash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> !(state_q == ST_RW && q_write));

    // Taking a request only happens on a cycle with no command on the bus.
    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sd_cs_n && sd_cke));

endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CAS_LAT = 3;
    localparam int T_RP    = 2;
    localparam int T_RCD   = 2;
    localparam int T_RFC   = 4;
    localparam int RW_GAP  = CAS_LAT + T_RP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_autopre = 1'b0;
    logic [22:0] req_addr = '0;
    logic [3:0]  req_mask = 4'hF;
    logic        ref_req = 1'b0;
    logic        pd_req = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_a;
    logic [3:0]  sd_dqm;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_seq #(
        .ROW_W(12), .COL_W(9), .BANK_W(2), .LANES(4),
        .CAS_LAT(CAS_LAT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre),
        .req_addr(req_addr), .req_mask(req_mask),
        .ref_req(ref_req), .pd_req(pd_req),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm)
    );

    // ---------------- reference model ----------------
    logic [22:0] qv[$];
    string       qt[$];
    bit          m_open[4];
    int          m_row[4];
    bit          m_pd = 1'b0;

    function automatic logic [22:0] mk(bit cke, logic [3:0] cmd, int ba, int a, logic [3:0] dqm);
        return {cke, cmd, 2'(ba), 12'(a), dqm};
    endfunction

    function automatic void push(logic [22:0] v, string t);
        qv.push_back(v);
        qt.push_back(t);
    endfunction

    task automatic push_access(input bit w, input bit ap, input logic [22:0] ad, input logic [3:0] m);
        int b = int'(ad[10:9]);
        int r = int'(ad[22:11]);
        int c = int'(ad[8:0]);
        int pos;
        bit hit;
        hit = m_open[b] && (m_row[b] == r);
        if (m_open[b] && !hit) begin
            push(mk(1, 4'b0010, b, 0, 4'hF), "R5");
            repeat (T_RP) push(mk(1, 4'hF, 0, 0, 4'hF), "R5");
        end
        if (!hit) begin
            push(mk(1, 4'b0011, b, r, 4'hF), "R2");
            repeat (T_RCD) push(mk(1, 4'hF, 0, 0, 4'hF), "R6");
        end
        pos = qv.size();
        push(mk(1, w ? 4'b0100 : 4'b0101, b, (ap ? 32'h400 : 0) | c, w ? m : 4'hF),
             hit ? "R4" : (w ? "R7" : "R3"));
        repeat (RW_GAP) push(mk(1, 4'hF, 0, 0, 4'hF), "R11");
        if (!w) begin
            qv[pos + CAS_LAT - 2][3:0] = m;
            qt[pos + CAS_LAT - 2] = "R8";
        end
        m_open[b] = !ap;
        m_row[b]  = r;
    endtask

    task automatic push_refresh();
        if (m_open[0] || m_open[1] || m_open[2] || m_open[3]) begin
            push(mk(1, 4'b0010, 0, 32'h400, 4'hF), "R9");
            repeat (T_RP) push(mk(1, 4'hF, 0, 0, 4'hF), "R9");
        end
        push(mk(1, 4'b0001, 0, 0, 4'hF), "R9");
        repeat (T_RFC) push(mk(1, 4'hF, 0, 0, 4'hF), "R9");
        for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [22:0] exp_v, act_v;
            string tag;
            bit was_idle, exp_rdy;
            was_idle = (qv.size() == 0) && !m_pd;
            if (qv.size() != 0) begin
                exp_v = qv.pop_front();
                tag   = qt.pop_front();
            end else if (m_pd) begin
                exp_v = mk(0, 4'hF, 0, 0, 4'hF); tag = "R10";
            end else begin
                exp_v = mk(1, 4'hF, 0, 0, 4'hF); tag = "R11";
            end
            act_v = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a, sd_dqm};
            n_vec++;
            if (act_v !== exp_v) begin
                n_err++;
                $display("FAIL %s: bus %h expected %h at %0t", tag, act_v, exp_v, $time);
            end
            exp_rdy = was_idle && !ref_req && !pd_req;
            n_vec++;
            if (req_ready !== exp_rdy) begin
                n_err++;
                $display("FAIL R12: req_ready %b expected %b at %0t", req_ready, exp_rdy, $time);
            end
            if (was_idle) begin
                if (ref_req)        push_refresh();
                else if (pd_req)    m_pd = 1'b1;
                else if (req_valid) push_access(req_write, req_autopre, req_addr, req_mask);
            end else if (m_pd && !pd_req) begin
                m_pd = 1'b0;
            end
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [22:0] addr(int row, int bank, int col);
        return {12'(row), 2'(bank), 9'(col)};
    endfunction

    task automatic access(input bit w, input bit ap, input logic [22:0] ad, input logic [3:0] m);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = w; req_autopre = ap; req_addr = ad; req_mask = m;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(qv.size() == 0 && !m_pd && req_ready));
    endtask

    task automatic pulse_ref();
        @(posedge clk); #1; ref_req = 1'b1;
        @(posedge clk); #1; ref_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not end, actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = 0; end
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if ({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a, sd_dqm, req_ready}
            !== {mk(1, 4'hF, 0, 0, 4'hF), 1'b1}) begin
            n_err++;
            $display("FAIL R1: reset bus %h ready %b expected %h ready 1",
                {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a, sd_dqm}, req_ready,
                mk(1, 4'hF, 0, 0, 4'hF));
        end
        @(posedge clk); #1; rst_n = 1'b1;

        access(0, 0, addr(5, 0, 3), 4'b0101);        // R6, R8: closed bank read
        wait_idle();
        access(1, 0, addr(5, 0, 7), 4'b0010);        // R4, R7: row hit write
        wait_idle();
        access(0, 0, addr(9, 0, 1), 4'b1000);        // R5: row miss
        wait_idle();
        access(1, 1, addr(12'hABC, 1, 9'h1FF), 4'b0000); // R3: auto-precharge, top column
        wait_idle();
        access(0, 0, addr(12'hABC, 1, 2), 4'b1111);  // R6: reopened after auto-precharge
        wait_idle();
        access(1, 0, addr(12'hFFF, 3, 0), 4'b0110);  // R2: top row, last bank
        wait_idle();
        pulse_ref();                                  // R9: banks open
        wait_idle();
        pulse_ref();                                  // R9: none open
        wait_idle();
        @(posedge clk); #1; pd_req = 1'b1;            // R10: power-down
        repeat (6) @(posedge clk);
        #1; pd_req = 1'b0;
        wait_idle();
        access(0, 1, addr(3, 2, 4), 4'b0011);        // R10: request during access
        @(posedge clk); #1; pd_req = 1'b1;
        repeat (15) @(posedge clk);
        #1; pd_req = 1'b0;
        wait_idle();
        access(1, 0, addr(7, 2, 8), 4'b1001);
        wait_idle();
        @(posedge clk); #1; ref_req = 1'b1; pd_req = 1'b1; // R12: refresh wins
        @(posedge clk); #1; ref_req = 1'b0;
        repeat (18) @(posedge clk);
        #1; pd_req = 1'b0;
        wait_idle();
        access(0, 0, addr(7, 2, 8), 4'b0100);        // R6: bank closed by refresh
        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule